// File: doc/BRIEF.md
# Auto-Reload Countdown Interrupt Timer

This block is a periodic interrupt timer built around a 16-bit down-counter. Software loads a preset value and picks one of four tick strobes (4096 Hz, 64 Hz, 1 Hz or one pulse per minute) as the count rate. When the enable bit goes high, the counter loads the preset and counts down once per selected tick. Each step from one to zero raises a sticky flag. The counter then reloads the preset on the same edge and keeps running, so the flag recurs at a fixed period.

A read-back port shows the preset while the timer is stopped and the live count while it runs. Software clears the flag by writing zero to it. The flag, gated by an interrupt-enable bit, drives one of two active-low interrupt outputs, chosen by a pin-select bit. The tick strobes come from a prescaler outside this block, and the register decode that produces the write strobes also lives outside it.

Top module: `reload_timer`

## Requirements
- R1: After a synchronous reset, the preset and the count are 0x0000, the flag is 0, and both `irq1_n` and `irq2_n` are high.
- R2: `src_sel` picks the count tick. Code 0 selects `tick_4k`, 1 selects `tick_64`, 2 selects `tick_1`, 3 selects `tick_60th`, and codes 4 to 7 select no tick. A strobe on any input that is not selected leaves the count unchanged.
- R3: On the first clock edge where `run_en` is 1 after being 0, the count loads the preset. Any tick at that edge is ignored.
- R4: A selected tick while the running count is 0x0001 is an expiry. On that edge the count reloads the preset and the flag is set. Counting then continues from the preset.
- R5: `rd_value` equals the preset while `run_en` is 0, and equals the live count while `run_en` is 1.
- R6: A flag write with `flag_wdata` = 0 clears the flag. A flag write with `flag_wdata` = 1 has no effect. An expiry on the same edge as a clearing write leaves the flag at 1.
- R7: Preset writes are ignored while `run_en` is 1.
- R8: While the flag and `irq_en` are both 1, `pin_sel` = 0 drives `irq1_n` low and `pin_sel` = 1 drives `irq2_n` low. The other output stays high. Otherwise both outputs are high.
- R9: While `run_en` is 0, ticks neither change the count nor produce an expiry.
- R10: A count of 0x0000 (preset 0) stays at zero under ticks and never produces an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| preset_we | input | 1 | Preset write strobe |
| preset_wdata | input | 16 | Preset write data |
| src_sel | input | 3 | Tick source select |
| run_en | input | 1 | Timer enable bit |
| irq_en | input | 1 | Interrupt enable bit |
| pin_sel | input | 1 | 0 routes the interrupt to irq1_n, 1 routes it to irq2_n |
| flag_clr_we | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data (only 0 has an effect) |
| tick_4k | input | 1 | 4096 Hz tick strobe |
| tick_64 | input | 1 | 64 Hz tick strobe |
| tick_1 | input | 1 | 1 Hz tick strobe |
| tick_60th | input | 1 | One-per-minute tick strobe |
| rd_value | output | 16 | Preset when stopped, live count when running |
| tmr_flag | output | 1 | Sticky expiry flag |
| irq1_n | output | 1 | First active-low interrupt output |
| irq2_n | output | 1 | Second active-low interrupt output |

## Verification
The countdown is driven under each source-select code, with strobes on the matching input and on non-matching inputs. This tells correct tick routing apart from any-strobe counting. It is also run with presets 3, 1, 0xFFFF and 0. These separate a normal multi-step expiry, an expiry on every tick, a plain wide decrement and the zero case that must never fire. Further patterns cover a stop then restart mid-count, which must restart from the preset rather than resume, and a preset write during a run. Flag writes of 1 and 0, each `pin_sel` value and `irq_en` = 0 show that the interrupt is routed and cleared correctly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W   = 16;
    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 4;

    // source select codes
    localparam logic [SEL_W-1:0] SRC_4K   = 3'd0;
    localparam logic [SEL_W-1:0] SRC_64   = 3'd1;
    localparam logic [SEL_W-1:0] SRC_1HZ  = 3'd2;
    localparam logic [SEL_W-1:0] SRC_60TH = 3'd3;

    typedef struct packed {
        logic run;
        logic irq_en;
        logic pin_sel;
    } tmr_ctrl_t;

    typedef struct packed {
        logic irq1_n;
        logic irq2_n;
    } tmr_pins_t;

    function automatic tmr_pins_t route_irq(input logic active, input logic sel);
        tmr_pins_t p;
        p.irq1_n = ~(active & ~sel);
        p.irq2_n = ~(active & sel);
        return p;
    endfunction

endpackage

// File: rtl/tmr_tick_mux.sv
module tmr_tick_mux #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 3
) (
    input  logic [NUM_SRC-1:0] ticks,
    input  logic [SEL_W-1:0]   src_sel,
    output logic               tick
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = ticks[i] & (src_sel == SEL_W'(i));
    end

    assign tick = |hit;

    always_comb begin
        if (src_sel >= SEL_W'(NUM_SRC))
            a_r2_unused_code_silent : assert (tick == 1'b0);
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run_en,
    input  logic             preset_we,
    input  logic [CNT_W-1:0] preset_wdata,
    output logic [CNT_W-1:0] preset_o,
    output logic [CNT_W-1:0] count_o,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] preset_q;
    logic [CNT_W-1:0] count_q;
    logic             en_q;
    logic             start;
    logic             step;

    assign start  = run_en & ~en_q;
    assign step   = run_en & en_q & tick & (count_q != '0);
    assign expire = step & (count_q == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            preset_q <= '0;
            count_q  <= '0;
            en_q     <= 1'b0;
        end else begin
            en_q <= run_en;
            if (preset_we && !run_en)
                preset_q <= preset_wdata;
            if (start || expire)
                count_q <= preset_q;
            else if (step)
                count_q <= count_q - ONE;
        end
    end

    assign preset_o = preset_q;
    assign count_o  = count_q;

    a_r3_start_loads_preset : assert property (@(posedge clk) disable iff (rst)
        start |=> (count_q == $past(preset_q)));
    a_r4_reload_on_expiry : assert property (@(posedge clk) disable iff (rst)
        expire |=> (count_q == $past(preset_q)));
    a_r7_preset_locked : assert property (@(posedge clk) disable iff (rst)
        run_en |=> $stable(preset_q));
    a_r9_halt_holds : assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(count_q));
    a_r10_zero_sticks : assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && !start) |=> (count_q == '0));
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      expire,
    input  logic      flag_clr_we,
    input  logic      flag_wdata,
    input  tmr_ctrl_t ctrl,
    output logic      flag,
    output tmr_pins_t pins
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (expire)
            flag_q <= 1'b1;
        else if (flag_clr_we && !flag_wdata)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign pins = route_irq(flag_q & ctrl.irq_en, ctrl.pin_sel);

    a_r6_event_sets_flag : assert property (@(posedge clk) disable iff (rst)
        expire |=> flag_q);
    a_r6_one_write_keeps : assert property (@(posedge clk) disable iff (rst)
        (flag_clr_we && flag_wdata && !expire) |=> (flag_q == $past(flag_q)));
    a_r8_single_pin : assert property (@(posedge clk) disable iff (rst)
        $onehot0({~pins.irq1_n, ~pins.irq2_n}));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          preset_we,
    input  logic [CW-1:0] preset_wdata,
    input  logic [SW-1:0] src_sel,
    input  logic          run_en,
    input  logic          irq_en,
    input  logic          pin_sel,
    input  logic          flag_clr_we,
    input  logic          flag_wdata,
    input  logic          tick_4k,
    input  logic          tick_64,
    input  logic          tick_1,
    input  logic          tick_60th,
    output logic [CW-1:0] rd_value,
    output logic          tmr_flag,
    output logic          irq1_n,
    output logic          irq2_n
);
    logic [NUM_SRC-1:0] ticks;
    logic               tick;
    logic               expire;
    logic [CW-1:0]      preset_q;
    logic [CW-1:0]      count_q;
    tmr_ctrl_t          ctrl;
    tmr_pins_t          pins;

    assign ticks = {tick_60th, tick_1, tick_64, tick_4k};
    assign ctrl  = '{run: run_en, irq_en: irq_en, pin_sel: pin_sel};

    tmr_tick_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SW)) u_mux (
        .ticks(ticks), .src_sel(src_sel), .tick(tick)
    );

    tmr_count_core #(.CNT_W(CW)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .run_en(ctrl.run),
        .preset_we(preset_we), .preset_wdata(preset_wdata),
        .preset_o(preset_q), .count_o(count_q), .expire(expire)
    );

    tmr_irq_route u_irq (
        .clk(clk), .rst(rst), .expire(expire), .flag_clr_we(flag_clr_we),
        .flag_wdata(flag_wdata), .ctrl(ctrl), .flag(tmr_flag), .pins(pins)
    );

    assign rd_value = ctrl.run ? count_q : preset_q;
    assign irq1_n   = pins.irq1_n;
    assign irq2_n   = pins.irq2_n;

    a_r1_reset_quiet : assert property (@(posedge clk)
        rst |=> (tmr_flag == 1'b0 && irq1_n && irq2_n));
endmodule

// File: tb/reload_timer_tb_top.sv
module reload_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        preset_we = 0;
    logic [15:0] preset_wdata = '0;
    logic [2:0]  src_sel = '0;
    logic        run_en = 0, irq_en = 0, pin_sel = 0;
    logic        flag_clr_we = 0, flag_wdata = 0;
    logic [3:0]  tk = '0;
    logic [15:0] rd_value;
    logic        tmr_flag, irq1_n, irq2_n;
    int          total = 0, bad = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    reload_timer dut_i (
        .clk(clk), .rst(rst), .preset_we(preset_we), .preset_wdata(preset_wdata),
        .src_sel(src_sel), .run_en(run_en), .irq_en(irq_en), .pin_sel(pin_sel),
        .flag_clr_we(flag_clr_we), .flag_wdata(flag_wdata),
        .tick_4k(tk[0]), .tick_64(tk[1]), .tick_1(tk[2]), .tick_60th(tk[3]),
        .rd_value(rd_value), .tmr_flag(tmr_flag), .irq1_n(irq1_n), .irq2_n(irq2_n)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_preset(logic [15:0] v);
        preset_we = 1; preset_wdata = v; step(); preset_we = 0;
    endtask

    task automatic wr_flag(logic v);
        flag_clr_we = 1; flag_wdata = v; step(); flag_clr_we = 0;
    endtask

    task automatic tick(int i);
        tk[i] = 1'b1; step(); tk = '0;
    endtask

    task automatic start(logic [15:0] p, logic [2:0] s);
        run_en = 0; step();
        wr_preset(p); src_sel = s;
        run_en = 1; step();
    endtask

    task automatic t_reset();
        rst = 1; step(); step(); rst = 0; step();
        chk("R1 rd_value", rd_value, 0);
        chk("R1 flag", tmr_flag, 0);
        chk("R1 irq pins", {irq1_n, irq2_n}, 2'b11);
    endtask

    task automatic t_basic();
        irq_en = 1; pin_sel = 0;
        start(16'd3, 3'd0);
        chk("R3 start load", rd_value, 3);
        tick(0); chk("R5 live count", rd_value, 2);
        tick(0); chk("R5 live count 1", rd_value, 1);
        chk("R4 no early flag", tmr_flag, 0);
        tick(0); chk("R4 reload", rd_value, 3);
        chk("R4 flag set", tmr_flag, 1);
        chk("R8 irq1 low", {irq1_n, irq2_n}, 2'b01);
        tick(0); chk("R4 keeps running", rd_value, 2);
    endtask

    task automatic t_flag();
        wr_flag(1'b1); chk("R6 write one ignored", tmr_flag, 1);
        pin_sel = 1; step();
        chk("R8 irq2 low", {irq1_n, irq2_n}, 2'b10);
        irq_en = 0; step();
        chk("R8 masked", {irq1_n, irq2_n}, 2'b11);
        irq_en = 1; wr_flag(1'b0);
        chk("R6 clear", tmr_flag, 0);
        chk("R8 released", {irq1_n, irq2_n}, 2'b11);
        // count is 2 here; tick to 1 then expire with clear on same edge
        tick(0);
        flag_clr_we = 1; flag_wdata = 0; tk[0] = 1; step(); flag_clr_we = 0; tk = '0;
        chk("R6 expiry beats clear", tmr_flag, 1);
        wr_flag(1'b0); pin_sel = 0;
    endtask

    task automatic t_sources();
        for (int s = 0; s < 4; s++) begin
            start(16'd10, 3'(s));
            for (int o = 0; o < 4; o++) if (o != s) tick(o);
            chk("R2 other strobes ignored", rd_value, 10);
            tick(s);
            chk("R2 selected strobe counts", rd_value, 9);
        end
        start(16'd10, 3'd7);
        for (int o = 0; o < 4; o++) tick(o);
        chk("R2 unused code no tick", rd_value, 10);
    endtask

    task automatic t_lock_restart();
        start(16'd3, 3'd1);
        wr_preset(16'd9);
        tick(1);
        chk("R5 running shows count", rd_value, 2);
        run_en = 0; step();
        chk("R7 preset unchanged", rd_value, 3);
        run_en = 1; step();
        chk("R3 restart from preset", rd_value, 3);
    endtask

    task automatic t_halt();
        start(16'd2, 3'd0);
        tick(0);
        run_en = 0; step();
        tick(0); tick(0);
        chk("R9 no event when stopped", tmr_flag, 0);
        chk("R5 stopped shows preset", rd_value, 2);
    endtask

    task automatic t_edges();
        start(16'd1, 3'd2);
        tick(2); chk("R4 preset one fires", tmr_flag, 1);
        chk("R4 preset one reload", rd_value, 1);
        wr_flag(1'b0);
        tick(2); chk("R4 preset one fires again", tmr_flag, 1);
        wr_flag(1'b0);
        start(16'hFFFF, 3'd3);
        tick(3); chk("R4 wide decrement", rd_value, 16'hFFFE);
        start(16'h0000, 3'd0);
        tick(0); tick(0);
        chk("R10 zero stays", rd_value, 0);
        chk("R10 zero no event", tmr_flag, 0);
        run_en = 0; step();
    endtask

    initial begin
        t_reset();
        t_basic();
        t_flag();
        t_sources();
        t_lock_restart();
        t_halt();
        t_edges();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule